// File: doc/BRIEF.md
# Operation-Tracking Computation Unit Controller

This controller follows a single operation from the cycle it is issued until every result has been stored. A one-cycle issue pulse, taken while the unit is idle, captures the operation fields and raises busy. Each source operand that the operation needs is then requested on its own port. The port raises a release output, and the operand is taken in the cycle when the matching go input is high. Ports run independently of each other, so go pulses can come in any order and after any number of stall cycles. Operand A can be forced to zero. Operand B can be replaced by an immediate value. A per-port mask can suppress any request.

When every required operand has been collected, the operands, the opcode and the invert-A flag are offered to the execution unit over a valid/ready handshake. The unit's results are accepted into a holding register. Each result port then raises a write release and drives the held value. A one-cycle write go on every port confirms storage, and only then does busy fall. An operation is therefore never dropped or left half-finished.

Top module: `optrack_cu`

## Requirements
- R1: After a synchronous reset, busy_o, rd_rel_o, wr_rel_o, eu_valid_o and eu_res_ready_o are all low.
- R2: issue_i sampled high while busy_o is low makes busy_o high in the next cycle. busy_o never rises without an issue. An issue pulse while busy_o is high is ignored and leaves the current operation's operands and results unchanged.
- R3: code_i, inv_a_i, imm_i, imm_ok_i, zero_a_i and rd_mask_i are captured on the issue cycle. Later changes to these inputs have no effect on eu_code_o, eu_inv_a_o or eu_ops_o.
- R4: In the first busy cycle, rd_rel_o[i] is high for every port the operation needs. It stays high through any number of stall cycles until rd_go_i[i] is sampled high.
- R5: src_i slice i is captured only in the cycle in which rd_go_i[i] and rd_rel_o[i] are both high. rd_rel_o[i] is low in the following cycle and stays low for the rest of the operation.
- R6: With zero_a_i set, port 0 is never requested and operand 0 (eu_ops_o bits [W-1:0]) is zero.
- R7: With imm_ok_i set, port 1 is never requested and operand 1 (eu_ops_o bits [2W-1:W]) equals the captured imm_i.
- R8: A set rd_mask_i[i] at issue suppresses the request on port i, and that operand is forwarded as zero. Ports without a mask, zero or immediate setting, including port 2, are requested.
- R9: eu_valid_o rises only after every needed operand has been collected. It stays high with eu_ops_o stable until eu_ready_i is sampled high, and it is offered once per operation.
- R10: eu_res_ready_o is high only after the operands have been accepted and before a result is taken. After eu_res_valid_i and eu_res_ready_o are both high, wr_rel_o goes high for all ports in the next cycle. dest_o slice j then holds result slice j of eu_res_i.
- R11: wr_rel_o[j] drops in the cycle after its wr_go_i[j] pulse. busy_o falls in the cycle after the last outstanding write go, and not before.
- R12: Read and write go pulses on different ports are accepted in any order and with any per-port delay, including zero delay in the cycle in which release first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | One-cycle issue pulse |
| code_i | input | OPW | Opcode |
| inv_a_i | input | 1 | Invert-operand-A flag |
| imm_i | input | W | Immediate value |
| imm_ok_i | input | 1 | Use immediate for operand 1 |
| zero_a_i | input | 1 | Use zero for operand 0 |
| rd_mask_i | input | NSRC | Per-port read suppression |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | NSRC | Operand read release per port |
| rd_go_i | input | NSRC | Operand read go per port |
| src_i | input | NSRC*W | Operand data, slice i for port i |
| eu_valid_o | output | 1 | Operands valid to execution unit |
| eu_ready_i | input | 1 | Execution unit accepts operands |
| eu_code_o | output | OPW | Latched opcode |
| eu_inv_a_o | output | 1 | Latched invert flag |
| eu_ops_o | output | NSRC*W | Collected operands |
| eu_res_valid_i | input | 1 | Result valid from execution unit |
| eu_res_ready_o | output | 1 | Controller accepts result |
| eu_res_i | input | NDST*W | Result data |
| wr_rel_o | output | NDST | Write release per result port |
| wr_go_i | input | NDST | Write go per result port |
| dest_o | output | NDST*W | Held result data |

## Verification
The embedded assertions check the handshake rules on every cycle. They cover busy rising only after an accepted issue and never on its own, release holding through stalls and dropping after go, release rising only in the first busy cycle, operand offers staying stable under backpressure, write release following a result handshake, and busy falling only after a write go. Only the bench scenarios can show the data effects. These are which operands are zeroed, replaced by the immediate or masked, that later field changes or a stray issue are ignored, that the forwarded operands and stored results carry the right values, and that every delay ordering completes with all reads and writes done exactly once.

// File: rtl/optrack_cu.sv
module optrack_cu #(
  parameter int W    = 16,
  parameter int NSRC = 3,
  parameter int NDST = 2,
  parameter int OPW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [OPW-1:0]    code_i,
  input  logic              inv_a_i,
  input  logic [W-1:0]      imm_i,
  input  logic              imm_ok_i,
  input  logic              zero_a_i,
  input  logic [NSRC-1:0]   rd_mask_i,
  output logic              busy_o,
  output logic [NSRC-1:0]   rd_rel_o,
  input  logic [NSRC-1:0]   rd_go_i,
  input  logic [NSRC*W-1:0] src_i,
  output logic              eu_valid_o,
  input  logic              eu_ready_i,
  output logic [OPW-1:0]    eu_code_o,
  output logic              eu_inv_a_o,
  output logic [NSRC*W-1:0] eu_ops_o,
  input  logic              eu_res_valid_i,
  output logic              eu_res_ready_o,
  input  logic [NDST*W-1:0] eu_res_i,
  output logic [NDST-1:0]   wr_rel_o,
  input  logic [NDST-1:0]   wr_go_i,
  output logic [NDST*W-1:0] dest_o
);
  localparam int SW = NSRC * W;
  localparam int DW = NDST * W;

  logic            busy_q, sent_q, have_q;
  logic [NSRC-1:0] need_q, got_q, need_d;
  logic [SW-1:0]   ops_q, init_d;
  logic [OPW-1:0]  code_q;
  logic            inv_q;
  logic [NDST-1:0] wdone_q;
  logic [DW-1:0]   res_q;

  logic            accept, all_got, finish;
  logic [NSRC-1:0] rd_take;
  logic [NDST-1:0] wr_take;

  assign accept         = issue_i & ~busy_q;
  assign rd_rel_o       = {NSRC{busy_q}} & need_q & ~got_q;
  assign rd_take        = rd_rel_o & rd_go_i;
  assign all_got        = &(got_q | ~need_q);
  assign eu_valid_o     = busy_q & all_got & ~sent_q;
  assign eu_res_ready_o = busy_q & sent_q & ~have_q;
  assign wr_rel_o       = {NDST{busy_q & have_q}} & ~wdone_q;
  assign wr_take        = wr_rel_o & wr_go_i;
  assign finish         = busy_q & have_q & (&(wdone_q | wr_take));

  assign busy_o     = busy_q;
  assign eu_ops_o   = ops_q;
  assign eu_code_o  = code_q;
  assign eu_inv_a_o = inv_q;
  assign dest_o     = res_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      need_d[i]           = ~rd_mask_i[i];
      init_d[i*W +: W]    = '0;
      if (i == 0 && zero_a_i) need_d[i] = 1'b0;
      if (i == 1 && imm_ok_i) begin
        need_d[i]        = 1'b0;
        init_d[i*W +: W] = rd_mask_i[i] ? '0 : imm_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      have_q  <= 1'b0;
      need_q  <= '0;
      got_q   <= '0;
      ops_q   <= '0;
      code_q  <= '0;
      inv_q   <= 1'b0;
      wdone_q <= '0;
      res_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      sent_q  <= 1'b0;
      have_q  <= 1'b0;
      need_q  <= need_d;
      got_q   <= '0;
      ops_q   <= init_d;
      code_q  <= code_i;
      inv_q   <= inv_a_i;
      wdone_q <= '0;
    end else begin
      got_q <= got_q | rd_take;
      for (int i = 0; i < NSRC; i++)
        if (rd_take[i]) ops_q[i*W +: W] <= src_i[i*W +: W];
      if (eu_valid_o && eu_ready_i) sent_q <= 1'b1;
      if (eu_res_ready_o && eu_res_valid_i) begin
        have_q <= 1'b1;
        res_q  <= eu_res_i;
      end
      wdone_q <= wdone_q | wr_take;
      if (finish) busy_q <= 1'b0;
    end
  end

  a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
    issue_i && !busy_o |=> busy_o);
  a_r2_no_self_rise: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !issue_i |=> !busy_o);

  for (genvar g = 0; g < NSRC; g++) begin : g_rd_chk
    a_r4_rel_holds: assert property (@(posedge clk) disable iff (rst)
      rd_rel_o[g] && !rd_go_i[g] |=> rd_rel_o[g]);
    a_r5_rel_drops: assert property (@(posedge clk) disable iff (rst)
      rd_rel_o[g] && rd_go_i[g] |=> !rd_rel_o[g]);
    a_r5_rise_once: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_rel_o[g]) |-> $past(issue_i && !busy_o));
  end

  a_r9_offer_stable: assert property (@(posedge clk) disable iff (rst)
    eu_valid_o && !eu_ready_i |=> eu_valid_o && $stable(eu_ops_o));
  a_r9_no_early_offer: assert property (@(posedge clk) disable iff (rst)
    eu_valid_o |-> (rd_rel_o == '0));
  a_r10_wr_after_res: assert property (@(posedge clk) disable iff (rst)
    $rose(|wr_rel_o) |-> $past(eu_res_valid_i && eu_res_ready_o));
  a_r11_wr_drops: assert property (@(posedge clk) disable iff (rst)
    |(wr_rel_o & wr_go_i) |=> !(|($past(wr_rel_o & wr_go_i) & wr_rel_o)));
  a_r11_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(|(wr_rel_o & wr_go_i)));
endmodule

// File: tb/optrack_cu_tb.sv
`timescale 1ns/1ps
module optrack_cu_tb_top;
  localparam int W = 16, NSRC = 3, NDST = 2, OPW = 4;

  logic clk = 0, rst = 1;
  logic issue_i = 0, inv_a_i = 0, imm_ok_i = 0, zero_a_i = 0;
  logic [OPW-1:0] code_i = 0;
  logic [W-1:0] imm_i = 0;
  logic [NSRC-1:0] rd_mask_i = 0, rd_go_i = 0, rd_rel_o;
  logic [NSRC*W-1:0] src_i = 0, eu_ops_o;
  logic busy_o, eu_valid_o, eu_ready_i = 0, eu_inv_a_o, eu_res_valid_i = 0, eu_res_ready_o;
  logic [OPW-1:0] eu_code_o;
  logic [NDST*W-1:0] eu_res_i = 0, dest_o;
  logic [NDST-1:0] wr_rel_o, wr_go_i = 0;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  optrack_cu #(.W(W), .NSRC(NSRC), .NDST(NDST), .OPW(OPW)) dut_i (
    .clk(clk), .rst(rst), .issue_i(issue_i), .code_i(code_i), .inv_a_i(inv_a_i),
    .imm_i(imm_i), .imm_ok_i(imm_ok_i), .zero_a_i(zero_a_i), .rd_mask_i(rd_mask_i),
    .busy_o(busy_o), .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i), .src_i(src_i),
    .eu_valid_o(eu_valid_o), .eu_ready_i(eu_ready_i), .eu_code_o(eu_code_o),
    .eu_inv_a_o(eu_inv_a_o), .eu_ops_o(eu_ops_o), .eu_res_valid_i(eu_res_valid_i),
    .eu_res_ready_o(eu_res_ready_o), .eu_res_i(eu_res_i), .wr_rel_o(wr_rel_o),
    .wr_go_i(wr_go_i), .dest_o(dest_o));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_r0(input logic [W-1:0] a, b, c, input logic inv);
    return (inv ? ~a : a) + b + c;
  endfunction
  function automatic logic [W-1:0] exp_r1(input logic [W-1:0] a, b, input logic [OPW-1:0] code);
    return a ^ b ^ {{(W-OPW){1'b0}}, code};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [OPW-1:0] code, input logic inv, input logic [W-1:0] imm,
                        input logic immok, input logic za, input logic [NSRC-1:0] mask,
                        input logic [W-1:0] s0, s1, s2, input int d0, d1, d2,
                        input int rdy, input int lat, input int w0, input int w1, input bit poke);
    logic [W-1:0] sv[NSRC], eo[NSRC], er[NDST];
    int dly[NSRC], cnt[NSRC], wd[NDST], wc[NDST];
    bit need[NSRC], got[NSRC], wdone[NDST];
    bit acc = 0, resd = 0, allg, alldone, ended = 0;
    int rc = 0, lc = 0;
    sv[0] = s0; sv[1] = s1; sv[2] = s2;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; wd[0] = w0; wd[1] = w1;
    for (int i = 0; i < NSRC; i++) begin
      cnt[i] = 0; got[i] = 0;
      need[i] = !mask[i] && !(i == 0 && za) && !(i == 1 && immok);
      eo[i] = need[i] ? sv[i] : '0;
    end
    if (immok && !mask[1]) eo[1] = imm;
    for (int j = 0; j < NDST; j++) begin wc[j] = 0; wdone[j] = 0; end
    er[0] = exp_r0(eo[0], eo[1], eo[2], inv);
    er[1] = exp_r1(eo[0], eo[1], code);

    chk(busy_o == 0, "R2 idle before issue", busy_o, 0);
    issue_i = 1; code_i = code; inv_a_i = inv; imm_i = imm; imm_ok_i = immok;
    zero_a_i = za; rd_mask_i = mask;
    @(negedge clk);
    issue_i = 0; code_i = OPW'($urandom); inv_a_i = ~inv; imm_i = W'($urandom);
    imm_ok_i = ~immok; zero_a_i = ~za; rd_mask_i = ~mask;
    chk(busy_o == 1, "R2 busy after issue", busy_o, 1);
    for (int i = 0; i < NSRC; i++)
      chk(rd_rel_o[i] == need[i], "R4 R6 R7 R8 first-cycle release", rd_rel_o[i], need[i]);

    for (int cyc = 0; cyc < 300; cyc++) begin
      alldone = 1;
      for (int j = 0; j < NDST; j++) alldone &= wdone[j];
      if (alldone) begin
        chk(busy_o == 0, "R11 busy falls after last write go", busy_o, 0);
        chk(rd_rel_o == 0 && wr_rel_o == 0, "R5 R11 releases low at end", {rd_rel_o, wr_rel_o}, 0);
        ended = 1;
        break;
      end
      chk(busy_o == 1, "R11 busy held until all writes", busy_o, 1);
      allg = 1;
      for (int i = 0; i < NSRC; i++) allg &= (got[i] || !need[i]);

      for (int j = 0; j < NDST; j++) begin
        wr_go_i[j] = 0;
        if (wr_rel_o[j]) begin
          if (!resd) chk(0, "R10 write release before result", wr_rel_o[j], 0);
          if (wc[j] >= wd[j]) begin
            wr_go_i[j] = 1; wdone[j] = 1;
            chk(dest_o[j*W +: W] == er[j], "R10 dest data", dest_o[j*W +: W], er[j]);
          end else wc[j]++;
        end else if (resd && !wdone[j]) chk(0, "R10 write release missing", 0, 1);
      end

      eu_res_valid_i = 0;
      if (acc && !resd) begin
        if (lc >= lat) begin
          eu_res_valid_i = 1; eu_res_i = {er[1], er[0]};
          if (eu_res_ready_o) resd = 1;
        end else lc++;
      end else if (!acc && eu_res_ready_o) chk(0, "R10 result ready before operands", 1, 0);

      eu_ready_i = 0;
      if (eu_valid_o) begin
        if (!allg || acc) chk(0, "R9 premature or repeated offer", eu_valid_o, 0);
        if (rc >= rdy) begin
          eu_ready_i = 1; acc = 1;
          for (int i = 0; i < NSRC; i++)
            chk(eu_ops_o[i*W +: W] == eo[i], "R5 R6 R7 R8 R9 operand value", eu_ops_o[i*W +: W], eo[i]);
          chk(eu_code_o == code && eu_inv_a_o == inv, "R3 latched fields", {eu_code_o, eu_inv_a_o}, {code, inv});
        end else rc++;
      end

      for (int i = 0; i < NSRC; i++) begin
        rd_go_i[i] = 0; src_i[i*W +: W] = W'($urandom);
        if (rd_rel_o[i]) begin
          if (!need[i]) chk(0, "R6 R7 R8 unexpected request", 1, 0);
          if (got[i]) chk(0, "R5 release after go", 1, 0);
          else if (cnt[i] >= dly[i]) begin
            rd_go_i[i] = 1; src_i[i*W +: W] = sv[i]; got[i] = 1;
          end else cnt[i]++;
        end else if (need[i] && !got[i]) chk(0, "R4 release dropped while stalled", 0, 1);
      end

      if (poke && cyc == 1) begin
        issue_i = 1; code_i = OPW'($urandom); imm_i = W'($urandom);
      end else issue_i = 0;
      @(negedge clk);
    end
    if (!ended) chk(0, "R11 operation did not complete", 0, 1);
    for (int i = 0; i < NSRC; i++) chk(got[i] == need[i], "R4 R12 each needed port read once", got[i], need[i]);
    rd_go_i = 0; wr_go_i = 0; eu_ready_i = 0; eu_res_valid_i = 0; issue_i = 0;
    rd_mask_i = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0 && rd_rel_o == 0 && wr_rel_o == 0 && eu_valid_o == 0 && eu_res_ready_o == 0,
        "R1 reset state", {busy_o, rd_rel_o, wr_rel_o, eu_valid_o, eu_res_ready_o}, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R2 no rise without issue", busy_o, 0);

    run_op(4'h3, 0, 16'h0, 0, 0, 3'b000, 16'd13, 16'd2, 16'd7, 0, 2, 0, 0, 0, 0, 0, 0);
    run_op(4'h5, 1, 16'h0, 0, 0, 3'b000, 16'd5, 16'd9, 16'd1, 3, 0, 1, 2, 3, 2, 0, 0);
    run_op(4'h1, 0, 16'h0008, 1, 1, 3'b100, 16'd5, 16'd2, 16'd4, 0, 0, 0, 0, 0, 1, 1, 0);
    run_op(4'h2, 0, 16'h0011, 1, 0, 3'b000, 16'hAAAA, 16'd2, 16'h0101, 1, 0, 4, 1, 1, 0, 3, 0);
    run_op(4'h7, 1, 16'h0, 0, 0, 3'b010, 16'h1234, 16'hFFFF, 16'h0F0F, 2, 0, 0, 0, 0, 3, 3, 0);
    run_op(4'h9, 0, 16'h0, 0, 1, 3'b000, 16'h4444, 16'h0005, 16'h0006, 0, 5, 0, 1, 2, 0, 1, 1);
    run_op(4'hC, 1, 16'h00FF, 0, 0, 3'b000, 16'h0001, 16'h0002, 16'h0003, 2, 2, 2, 0, 0, 0, 0, 1);

    for (int k = 0; k < 40; k++) begin
      logic [NSRC-1:0] m;
      for (int i = 0; i < NSRC; i++) m[i] = ($urandom % 4) == 0;
      run_op(OPW'($urandom), 1'($urandom), W'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0, m,
             W'($urandom), W'($urandom), W'($urandom),
             $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 3, $urandom % 4,
             $urandom % 3, $urandom % 3, ($urandom % 4) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule